// File: doc/BRIEF.md
# Multi-Input Switch Polling Sequencer

This block runs a timed scan over a bank of switch inputs (24 by default) so that the wetting current for each switch is on only for a short window inside a much longer poll period. Once software raises the trigger input, the sequencer visits the inputs one after another. For each input it drives a wetting-current enable for a programmable active window. It then captures that input's detection result (a comparator decision delivered on `sense_in`) on the last tick of the window.

When the first full scan after arming completes, its samples become the stored baseline. The block then pulls the active-low interrupt and raises a status-change flag. On each later scan, the freshly sampled vector is compared with the stored one. Any difference updates the stored status, accumulates the changed bits into a change mask and raises the interrupt again. A one-cycle read strobe from the register interface releases the interrupt and clears the flag and the mask. The scan timing comes from a microsecond tick, produced by a clock prescaler, and two code fields that select the window and the period in powers of two.

Top module: `switch_poll_seq`

## Requirements
- R1: At most one bit of `wet_en` is high at any time. Each input's bit stays high for exactly `ACT_UNIT_US << n` ticks, where n is `act_code`. Between scans `wet_en` is zero.
- R2: The value of `sense_in[i]` that is stored is the one present during the last tick of input i's window. A value present only earlier in that window has no effect.
- R3: Within a scan, the inputs are visited in ascending order, bit 0 first and bit NUM_IN-1 last.
- R4: Successive scans start `POLL_UNIT_US << m` ticks apart, where m is `poll_code`. One tick lasts TICK_DIV clock cycles.
- R5: No scan starts while `trigger` is low. The first scan that completes after `trigger` is raised from idle always loads `status`, drives `int_n` low and sets `ssc_flag`, even if the samples equal the old status.
- R6: On later scans, `int_n` falls and `status` takes the new samples only if at least one sampled bit differs from `status`.
- R7: A cycle with `rd_clr` high sets `int_n` to 1 and clears `ssc_flag` and `chg_mask`. If a scan raises an event in the same cycle, the event wins.
- R8: A switch change that happens and reverts between two sampling instants leaves `status` unchanged and raises no interrupt.
- R9: `chg_mask` ORs in the set of differing bits from each changed scan until it is cleared by a read. The first scan after arming does not alter it.
- R10: Window codes 6 and 7 act as code 5 (32 units). Period codes 12 to 15 act as code 11 (2048 units).
- R11: If the period is shorter than NUM_IN windows, the next scan starts immediately after the last sample, giving a start-to-start spacing of NUM_IN windows.
- R12: When `trigger` is low at the end of a period, the block goes idle with `wet_en` zero and keeps `status`.
- R13: After reset, `int_n` is 1 and `wet_en`, `status`, `chg_mask` and `ssc_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigger | input | 1 | Scan enable bit from software |
| act_code | input | 3 | Active window code, n in ACT_UNIT_US << n |
| poll_code | input | 4 | Poll period code, m in POLL_UNIT_US << m |
| sense_in | input | NUM_IN | Per-input detection result from the comparators |
| rd_clr | input | 1 | Interrupt status read strobe, clears on read |
| wet_en | output | NUM_IN | Per-input wetting-current enable |
| int_n | output | 1 | Active-low interrupt |
| ssc_flag | output | 1 | Switch-status-change flag |
| status | output | NUM_IN | Stored per-input switch status |
| chg_mask | output | NUM_IN | Inputs that changed since the last read |

## Verification
Several properties are checked on every cycle: the enable is one-hot and only ever steps upward, the flag always mirrors the interrupt, a plain read always releases the interrupt, and the stored status and change mask never move without the interrupt being asserted. Other behaviours can only be shown by the bench's scenarios. These are the exact window and period lengths (including code saturation and back-to-back scans), the capture of a sample on the last tick of its window, the suppression of glitches that fall between samples, the unconditional interrupt after re-arming, and the accumulation of the change mask.

// File: rtl/swpoll_pkg.sv
package swpoll_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_ACTIVE, PS_WAIT} poll_state_t;

  localparam int ACT_MAX_EXP  = 5;
  localparam int POLL_MAX_EXP = 11;

  function automatic logic [2:0] sat_act(input logic [2:0] c);
    return (c > 3'(ACT_MAX_EXP)) ? 3'(ACT_MAX_EXP) : c;
  endfunction

  function automatic logic [3:0] sat_poll(input logic [3:0] c);
    return (c > 4'(POLL_MAX_EXP)) ? 4'(POLL_MAX_EXP) : c;
  endfunction
endpackage

// File: rtl/swp_tick_gen.sv
module swp_tick_gen #(
  parameter int TICK_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + CW'(1);
      tick <= (cnt == LAST);
    end
  end
endmodule

// File: rtl/swp_scan_ctrl.sv
module swp_scan_ctrl
  import swpoll_pkg::*;
#(
  parameter int NUM_IN       = 24,
  parameter int ACT_UNIT_US  = 64,
  parameter int POLL_UNIT_US = 2000,
  localparam int IDX_W       = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              trigger,
  input  logic [2:0]        act_code,
  input  logic [3:0]        poll_code,
  output logic [NUM_IN-1:0] wet_en,
  output logic [IDX_W-1:0]  idx,
  output logic              sample_stb,
  output logic              scan_end,
  output logic              scan_arm
);
  localparam int ACT_W  = $clog2(ACT_UNIT_US * (1 << ACT_MAX_EXP) + 1);
  localparam int POLL_W = $clog2(POLL_UNIT_US * (1 << POLL_MAX_EXP) + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_IN - 1);

  poll_state_t       state;
  logic [ACT_W-1:0]  act_cnt, act_len;
  logic [POLL_W-1:0] per_cnt, per_len;
  logic              per_done, last_in;

  always_comb begin
    act_len    = ACT_W'(ACT_UNIT_US) << sat_act(act_code);
    per_len    = POLL_W'(POLL_UNIT_US) << sat_poll(poll_code);
    per_done   = per_cnt >= per_len - POLL_W'(1);
    last_in    = idx == IDX_LAST;
    sample_stb = (state == PS_ACTIVE) && tick && (act_cnt >= act_len - ACT_W'(1));
    scan_end   = sample_stb && last_in;
    scan_arm   = (state == PS_IDLE) && trigger;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_IDLE;
      idx     <= '0;
      act_cnt <= '0;
      per_cnt <= '0;
      wet_en  <= '0;
    end else begin
      unique case (state)
        PS_IDLE: if (trigger) begin
          state   <= PS_ACTIVE;
          idx     <= '0;
          act_cnt <= '0;
          per_cnt <= '0;
          wet_en  <= NUM_IN'(1);
        end
        PS_ACTIVE: if (tick) begin
          if (!per_done) per_cnt <= per_cnt + POLL_W'(1);
          if (!sample_stb) begin
            act_cnt <= act_cnt + ACT_W'(1);
          end else begin
            act_cnt <= '0;
            if (!last_in) begin
              idx    <= idx + IDX_W'(1);
              wet_en <= wet_en << 1;
            end else if (per_done && trigger) begin
              idx     <= '0;
              per_cnt <= '0;
              wet_en  <= NUM_IN'(1);
            end else begin
              state  <= per_done ? PS_IDLE : PS_WAIT;
              wet_en <= '0;
            end
          end
        end
        PS_WAIT: if (tick) begin
          if (!per_done) begin
            per_cnt <= per_cnt + POLL_W'(1);
          end else if (trigger) begin
            state   <= PS_ACTIVE;
            idx     <= '0;
            act_cnt <= '0;
            per_cnt <= '0;
            wet_en  <= NUM_IN'(1);
          end else begin
            state <= PS_IDLE;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swp_status_reg.sv
module swp_status_reg #(
  parameter int NUM_IN = 24,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NUM_IN-1:0] sense_in,
  input  logic              scan_end,
  input  logic              scan_arm,
  input  logic              rd_clr,
  output logic [NUM_IN-1:0] status,
  output logic [NUM_IN-1:0] chg_mask,
  output logic              ssc_flag,
  output logic              int_n
);
  logic [NUM_IN-1:0] scan_buf, cur, diff;
  logic              have_base;

  always_comb begin
    cur      = scan_buf;
    cur[idx] = sense_in[idx];
    diff     = cur ^ status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_buf  <= '0;
      status    <= '0;
      chg_mask  <= '0;
      ssc_flag  <= 1'b0;
      int_n     <= 1'b1;
      have_base <= 1'b0;
    end else begin
      if (sample_stb) scan_buf <= cur;
      if (scan_arm)   have_base <= 1'b0;
      if (rd_clr) begin
        chg_mask <= '0;
        ssc_flag <= 1'b0;
        int_n    <= 1'b1;
      end
      if (scan_end) begin
        if (!have_base) begin
          status    <= cur;
          have_base <= 1'b1;
          ssc_flag  <= 1'b1;
          int_n     <= 1'b0;
        end else if (|diff) begin
          status   <= cur;
          chg_mask <= (rd_clr ? '0 : chg_mask) | diff;
          ssc_flag <= 1'b1;
          int_n    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/switch_poll_seq.sv
module switch_poll_seq #(
  parameter int NUM_IN       = 24,
  parameter int TICK_DIV     = 50,
  parameter int ACT_UNIT_US  = 64,
  parameter int POLL_UNIT_US = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigger,
  input  logic [2:0]        act_code,
  input  logic [3:0]        poll_code,
  input  logic [NUM_IN-1:0] sense_in,
  input  logic              rd_clr,
  output logic [NUM_IN-1:0] wet_en,
  output logic              int_n,
  output logic              ssc_flag,
  output logic [NUM_IN-1:0] status,
  output logic [NUM_IN-1:0] chg_mask
);
  localparam int IDX_W = $clog2(NUM_IN);

  logic             tick, sample_stb, scan_end, scan_arm;
  logic [IDX_W-1:0] idx;

  swp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  swp_scan_ctrl #(
    .NUM_IN(NUM_IN), .ACT_UNIT_US(ACT_UNIT_US), .POLL_UNIT_US(POLL_UNIT_US)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .trigger(trigger),
    .act_code(act_code), .poll_code(poll_code), .wet_en(wet_en), .idx(idx),
    .sample_stb(sample_stb), .scan_end(scan_end), .scan_arm(scan_arm)
  );

  swp_status_reg #(.NUM_IN(NUM_IN)) u_stat (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .idx(idx),
    .sense_in(sense_in), .scan_end(scan_end), .scan_arm(scan_arm),
    .rd_clr(rd_clr), .status(status), .chg_mask(chg_mask),
    .ssc_flag(ssc_flag), .int_n(int_n)
  );
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int NUM_IN = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_clr,
  input logic              scan_end,
  input logic [NUM_IN-1:0] wet_en,
  input logic              int_n,
  input logic              ssc_flag,
  input logic [NUM_IN-1:0] status,
  input logic [NUM_IN-1:0] chg_mask
);
  // R1: one wetting enable at most
  a_r1_wet_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wet_en));

  // R3: the enable moves only to the next higher input, or wraps to input 0
  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    (wet_en != '0 && $past(wet_en) != '0 && wet_en != $past(wet_en))
      |-> (wet_en == ($past(wet_en) << 1) || wet_en == NUM_IN'(1)));

  // R7: a read with no coincident event releases everything
  a_r7_read_release: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !scan_end) |=> (int_n && !ssc_flag && chg_mask == '0));

  // R5: flag and interrupt always agree
  a_r5_flag_tracks_irq: assert property (@(posedge clk) disable iff (rst)
    ssc_flag == !int_n);

  // R6: status only moves together with an asserted interrupt
  a_r6_status_needs_irq: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> (!int_n && ssc_flag));

  // R9: a newly grown change mask comes with an interrupt
  a_r9_mask_needs_irq: assert property (@(posedge clk) disable iff (rst)
    (chg_mask != $past(chg_mask) && chg_mask != '0) |-> !int_n);
endmodule

bind switch_poll_seq swp_checker #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst(rst), .rd_clr(rd_clr), .scan_end(scan_end),
  .wet_en(wet_en), .int_n(int_n), .ssc_flag(ssc_flag),
  .status(status), .chg_mask(chg_mask)
);

// File: tb/sim_switch_poll_seq.sv
module sim_switch_poll_seq;
  localparam int N  = 24;
  localparam int AU = 2;
  localparam int PU = 4;

  logic         clk = 1'b0, rst = 1'b1, trigger = 1'b0, rd_clr = 1'b0;
  logic [2:0]   act_code = 3'd0;
  logic [3:0]   poll_code = 4'd5;
  logic [N-1:0] sense_in = '0;
  logic [N-1:0] wet_en, status, chg_mask;
  logic         int_n, ssc_flag;

  switch_poll_seq #(.NUM_IN(N), .TICK_DIV(1), .ACT_UNIT_US(AU), .POLL_UNIT_US(PU)) u0 (
    .clk(clk), .rst(rst), .trigger(trigger), .act_code(act_code),
    .poll_code(poll_code), .sense_in(sense_in), .rd_clr(rd_clr),
    .wet_en(wet_en), .int_n(int_n), .ssc_flag(ssc_flag),
    .status(status), .chg_mask(chg_mask)
  );

  always #10 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic cur0 = 1'b0, prev0 = 1'b0;
  always @(posedge clk) begin
    prev0 = cur0;
    #1 cur0 = wet_en[0];
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_rd();
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
  endtask

  // Waits for a scan start, drives sense_in per cycle (one optional glitch),
  // counts cycles where wet_en differs from the expected one-hot position.
  task automatic run_scan(input logic [N-1:0] base, input int gidx, input int gcyc,
                          input int al, output longint t0, output int bad);
    logic [N-1:0] one;
    one = N'(1);
    bad = 0;
    while (!(wet_en[0] && !prev0)) @(negedge clk);
    t0 = cyc;
    for (int k = 0; k < N * al; k++) begin
      if (k != 0) @(negedge clk);
      sense_in = base;
      if (gidx >= 0 && k == gidx * al + gcyc) sense_in[gidx] = ~base[gidx];
      if (wet_en != (one << (k / al))) bad++;
    end
    @(negedge clk);
    sense_in = base;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a, b;
    longint t0, t1, t2, t3;
    int bad;
    a = 24'h5A3C96;
    b = a ^ 24'h800001;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(int_n && !ssc_flag, "R13", "int_n/ssc", {int_n, ssc_flag}, 2'b10);
    check(wet_en == 0 && status == 0 && chg_mask == 0, "R13", "wet/status/mask",
          wet_en | status | chg_mask, 0);

    // R5 no scan without trigger
    bad = 0;
    repeat (20) begin @(negedge clk); if (wet_en != 0) bad++; end
    check(bad == 0, "R5", "wet_en active while untriggered", bad, 0);

    // First scan: R1/R3 order and windows, R5 unconditional interrupt
    sense_in = a;
    trigger = 1'b1;
    run_scan(a, -1, 0, AU, t0, bad);
    check(bad == 0, "R3", "order/window mismatch cycles", bad, 0);
    check(wet_en == 0, "R1", "wet_en between scans", wet_en, 0);
    check(status == a, "R5", "baseline status", status, a);
    check(!int_n && ssc_flag, "R5", "first-scan irq", {int_n, ssc_flag}, 2'b01);
    check(chg_mask == 0, "R9", "mask after first scan", chg_mask, 0);

    repeat (5) @(negedge clk);
    pulse_rd();
    check(int_n && !ssc_flag, "R7", "read release", {int_n, ssc_flag}, 2'b10);

    // R8 glitch between samples, R4 period
    sense_in = ~a;
    repeat (20) @(negedge clk);
    sense_in = a;
    run_scan(a, -1, 0, AU, t1, bad);
    check(t1 - t0 == longint'(PU << 5), "R4", "start spacing", t1 - t0, PU << 5);
    check(int_n, "R8", "irq after glitch", int_n, 1);
    check(status == a, "R8", "status after glitch", status, a);

    // R2 early-window flip ignored
    run_scan(a, 3, 0, AU, t0, bad);
    check(int_n && status == a, "R2", "early flip status", status, a);

    // R2 last-tick flip captured, R6 change interrupt
    run_scan(a, 5, AU - 1, AU, t0, bad);
    check(status == (a ^ 24'h20), "R2", "last-tick flip status", status, a ^ 24'h20);
    check(chg_mask == 24'h20, "R6", "change mask", chg_mask, 24'h20);
    check(!int_n && ssc_flag, "R6", "change irq", {int_n, ssc_flag}, 2'b01);

    // R9 accumulation without read
    sense_in = b;
    run_scan(b, -1, 0, AU, t0, bad);
    check(status == b, "R6", "status update", status, b);
    check(chg_mask == 24'h800021, "R9", "accumulated mask", chg_mask, 24'h800021);
    pulse_rd();
    check(chg_mask == 0 && int_n, "R7", "mask cleared", chg_mask, 0);

    // R12 trigger low -> idle, status kept
    trigger = 1'b0;
    bad = 0;
    repeat (400) begin @(negedge clk); if (wet_en != 0) bad++; end
    check(bad == 0, "R12", "wet_en after disarm", bad, 0);
    check(status == b && int_n, "R12", "status kept", status, b);

    // R5 re-arm interrupts with unchanged inputs
    trigger = 1'b1;
    run_scan(b, -1, 0, AU, t0, bad);
    check(!int_n && status == b, "R5", "re-arm irq", int_n, 0);
    poll_code = 4'd15;
    pulse_rd();

    // R10 period saturation
    run_scan(b, -1, 0, AU, t0, bad);
    run_scan(b, -1, 0, AU, t1, bad);
    check(t1 - t0 == longint'(PU << 11), "R10", "saturated period", t1 - t0, PU << 11);

    // R11 back-to-back with short period
    poll_code = 4'd0;
    run_scan(b, -1, 0, AU, t0, bad);
    run_scan(b, -1, 0, AU, t1, bad);
    check(t1 - t0 == longint'(N * AU), "R11", "back-to-back spacing", t1 - t0, N * AU);

    // R10 window saturation, R11 spacing with long windows
    act_code = 3'd7;
    run_scan(b, -1, 0, AU << 5, t2, bad);
    check(bad == 0, "R10", "saturated window mismatches", bad, 0);
    run_scan(b, -1, 0, AU << 5, t3, bad);
    check(t3 - t2 == longint'(N * (AU << 5)), "R11", "long-window spacing",
          t3 - t2, N * (AU << 5));
    check(int_n, "R6", "no irq on steady inputs", int_n, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule